// File: doc/BRIEF.md
# Memory-Mapped Vectored Interrupt Controller

This block merges up to 32 interrupt request lines into a single interrupt output for a processor. It records each request in a status register and masks that register with a per-source enable register. The masked result is the pending set, and it drives the output. Software works the block through a plain 32-bit register bus: an address, a write strobe with write data, and a read strobe with combinational read data.

Software services an interrupt in a fixed sequence. It reads the vector register to get the lowest-numbered pending source. It handles that source, then writes a 1 to that source's bit in the acknowledge register. Enable bits can be changed one at a time through two alias registers: one only sets bits and the other only clears them, so no read-modify-write is needed. A two-bit master control gates the whole block. Each line is sensed either on its rising edge or on its level, and that choice is fixed per line by a build-time mask.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, the status, enable and master registers read 0, the vector register reads 0xFFFFFFFF, and irqOut is low.
- R2: A source whose bit in EDGE_MASK is 1 (by default, sources 0 to 15) sets its status bit only on a 0-to-1 transition of its input. Holding the input high does not set the bit again after it is acknowledged.
- R3: A source whose bit in EDGE_MASK is 0 (by default, sources 16 to 31) sets its status bit on every cycle its input is high. If it is acknowledged while the line is still high, the bit stays set.
- R4: A write to the acknowledge register at byte address 12 clears each status bit whose written bit is 1 and leaves the other status bits unchanged. Writing 0xFFFFFFFF clears all of them. The register reads as 0.
- R5: A write to byte address 16 sets each enable bit whose written bit is 1 and leaves the other enable bits unchanged.
- R6: A write to byte address 20 clears each enable bit whose written bit is 1 and leaves the other enable bits unchanged.
- R7: A write to byte address 8 loads the whole enable register, and a read there returns it.
- R8: A read of byte address 4 returns status AND enable. Writes to that address change nothing.
- R9: A read of byte address 24 returns the index of the lowest-numbered pending source, or 0xFFFFFFFF when no source is pending.
- R10: The master register at byte address 28 holds two bits. irqOut is high only when both bits are 1 and at least one source is pending. While bit 1 is 0, input lines set no status bits.
- R11: The status register at byte address 0 is read-only. Writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | NUM_SRC | Interrupt request lines |
| busAddr | input | ADDR_W | Byte address of the register |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 32 | Read data, combinational; 0 when busRdEn is low |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
On every cycle, the assertions check four things: after an acknowledge write, no status bit that was written as 1 remains set unless its line set it again in that cycle; the set-enable and clear-enable aliases touch only the addressed bits; no status bit appears while master bit 1 is low; and every vector read names a source that is actually pending. Only the bench scenarios can show the difference between edge and level sensing: an edge source that is held high stays cleared after acknowledge, while a level source re-latches. The same holds for lowest-index vector priority, the read-only behaviour of the status and pending addresses, and irqOut tracking both master bits.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  localparam int DATA_W = 32;

  // byte offsets; software depends on this layout
  localparam logic [7:0] OFS_STATUS  = 8'd0;
  localparam logic [7:0] OFS_PENDING = 8'd4;
  localparam logic [7:0] OFS_ENABLE  = 8'd8;
  localparam logic [7:0] OFS_ACK     = 8'd12;
  localparam logic [7:0] OFS_SET_EN  = 8'd16;
  localparam logic [7:0] OFS_CLR_EN  = 8'd20;
  localparam logic [7:0] OFS_VECTOR  = 8'd24;
  localparam logic [7:0] OFS_MASTER  = 8'd28;

  typedef struct packed {
    logic              enWr;
    logic              setEnWr;
    logic              clrEnWr;
    logic              ackWr;
    logic              masterWr;
    logic [DATA_W-1:0] wdata;
  } ctrlStrobe_t;

endpackage

// File: rtl/irq_ctrl_datapath.sv
module irq_ctrl_datapath
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = '1,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  ctrlStrobe_t        strobe,
  output logic [NUM_SRC-1:0] statusQ,
  output logic [NUM_SRC-1:0] enableQ,
  output logic [NUM_SRC-1:0] pending,
  output logic [1:0]         masterQ,
  output logic               vecValid,
  output logic [IDX_W-1:0]   vecIdx,
  output logic               irqOut
);

  logic [NUM_SRC-1:0] irqPrev;
  logic [NUM_SRC-1:0] setVec;
  logic [NUM_SRC-1:0] ackMask;

  // per-line sense, fixed at build time
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sense
    if (EDGE_MASK[i]) begin : g_edge
      assign setVec[i] = irqIn[i] & ~irqPrev[i];
    end else begin : g_level
      assign setVec[i] = irqIn[i];
    end
  end

  assign ackMask = strobe.ackWr ? strobe.wdata[NUM_SRC-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPrev <= '0;
      statusQ <= '0;
    end else begin
      irqPrev <= irqIn;
      // a set in the same cycle wins over the acknowledge
      statusQ <= (statusQ & ~ackMask) | (setVec & {NUM_SRC{masterQ[1]}});
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= '0;
    end else if (strobe.enWr) begin
      enableQ <= strobe.wdata[NUM_SRC-1:0];
    end else if (strobe.setEnWr) begin
      enableQ <= enableQ | strobe.wdata[NUM_SRC-1:0];
    end else if (strobe.clrEnWr) begin
      enableQ <= enableQ & ~strobe.wdata[NUM_SRC-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      masterQ <= 2'b00;
    end else if (strobe.masterWr) begin
      masterQ <= strobe.wdata[1:0];
    end
  end

  assign pending = statusQ & enableQ;

  // lowest index has priority
  always_comb begin
    vecValid = 1'b0;
    vecIdx   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pending[i]) begin
        vecValid = 1'b1;
        vecIdx   = IDX_W'(i);
      end
    end
  end

  assign irqOut = (&masterQ) & (|pending);

  // R4: acknowledged bits are gone unless a line set them again
  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ackWr |=> ((statusQ & $past(strobe.wdata[NUM_SRC-1:0]) & ~$past(setVec)) == '0));

  // R5: set alias forces written ones
  a_r5_set_en: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setEnWr |=> ((enableQ & $past(strobe.wdata[NUM_SRC-1:0])) == $past(strobe.wdata[NUM_SRC-1:0])));

  // R6: clear alias removes written ones
  a_r6_clr_en: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrEnWr |=> ((enableQ & $past(strobe.wdata[NUM_SRC-1:0])) == '0));

  // R10: no new status bit while hardware latching is off
  a_r10_no_latch_off: assert property (@(posedge clk) disable iff (!rstN)
    !masterQ[1] |=> ((statusQ & ~$past(statusQ)) == '0));

endmodule

// File: rtl/irq_ctrl_decode.sv
module irq_ctrl_decode
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 5,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [DATA_W-1:0]  busWrData,
  input  logic               busRdEn,
  input  logic [NUM_SRC-1:0] statusQ,
  input  logic [NUM_SRC-1:0] enableQ,
  input  logic [NUM_SRC-1:0] pending,
  input  logic [1:0]         masterQ,
  input  logic               vecValid,
  input  logic [IDX_W-1:0]   vecIdx,
  output ctrlStrobe_t        strobe,
  output logic [DATA_W-1:0]  busRdData
);

  logic [7:0] byteAddr;
  assign byteAddr = 8'(busAddr);

  always_comb begin
    strobe          = '0;
    strobe.wdata    = busWrData;
    strobe.enWr     = busWrEn && (byteAddr == OFS_ENABLE);
    strobe.setEnWr  = busWrEn && (byteAddr == OFS_SET_EN);
    strobe.clrEnWr  = busWrEn && (byteAddr == OFS_CLR_EN);
    strobe.ackWr    = busWrEn && (byteAddr == OFS_ACK);
    strobe.masterWr = busWrEn && (byteAddr == OFS_MASTER);
  end

  always_comb begin
    busRdData = '0;
    if (busRdEn) begin
      unique case (byteAddr)
        OFS_STATUS:  busRdData = DATA_W'(statusQ);
        OFS_PENDING: busRdData = DATA_W'(pending);
        OFS_ENABLE:  busRdData = DATA_W'(enableQ);
        OFS_VECTOR:  busRdData = vecValid ? DATA_W'(vecIdx) : '1;
        OFS_MASTER:  busRdData = DATA_W'(masterQ);
        default:     busRdData = '0;
      endcase
    end
  end

  // R9: a returned vector always names a pending source
  a_r9_vec_pending: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && byteAddr == OFS_VECTOR && busRdData != '1) |-> pending[busRdData[IDX_W-1:0]]);

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 5,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = NUM_SRC'(32'h0000_FFFF)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [31:0]        busWrData,
  input  logic               busRdEn,
  output logic [31:0]        busRdData,
  output logic               irqOut
);

  localparam int IDX_W = $clog2(NUM_SRC);

  ctrlStrobe_t        strobe;
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] enableQ;
  logic [NUM_SRC-1:0] pending;
  logic [1:0]         masterQ;
  logic               vecValid;
  logic [IDX_W-1:0]   vecIdx;

  irq_ctrl_decode #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_decode (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData), .busRdEn(busRdEn),
    .statusQ(statusQ), .enableQ(enableQ), .pending(pending), .masterQ(masterQ),
    .vecValid(vecValid), .vecIdx(vecIdx),
    .strobe(strobe), .busRdData(busRdData)
  );

  irq_ctrl_datapath #(.NUM_SRC(NUM_SRC), .EDGE_MASK(EDGE_MASK)) u_datapath (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .strobe(strobe),
    .statusQ(statusQ), .enableQ(enableQ), .pending(pending), .masterQ(masterQ),
    .vecValid(vecValid), .vecIdx(vecIdx), .irqOut(irqOut)
  );

endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqIn = '0;
  logic [4:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic        irqOut;

  int checkCnt = 0;
  int failCnt  = 0;
  bit finished = 1'b0;

  typedef struct {
    bit          isIrq;
    logic [31:0] exp;
    string       req;
  } expItem_t;

  expItem_t expQ[$];

  always #4 clk = ~clk;  // 125 MHz

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdEn(busRdEn),
    .busRdData(busRdData), .irqOut(irqOut)
  );

  // monitor: samples between the falling and the next rising edge
  always begin
    @(negedge clk);
    #2;
    while (expQ.size() > 0) begin
      expItem_t it;
      logic [31:0] act;
      it  = expQ.pop_front();
      act = it.isIrq ? {31'd0, irqOut} : busRdData;
      checkCnt++;
      if (act !== it.exp) begin
        failCnt++;
        $display("FAIL %s: actual 0x%08h expected 0x%08h", it.req, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [4:0] a, input logic [31:0] e, input string req);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    expQ.push_back('{1'b0, e, req});
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic irqChk(input logic e, input string req);
    @(negedge clk);
    expQ.push_back('{1'b1, {31'd0, e}, req});
  endtask

  task automatic drive(input logic [31:0] v);
    @(negedge clk);
    irqIn = v;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rdChk(5'd0,  32'h0, "R1 status");
    rdChk(5'd8,  32'h0, "R1 enable");
    rdChk(5'd28, 32'h0, "R1 master");
    rdChk(5'd24, 32'hFFFF_FFFF, "R1 vector");
    irqChk(1'b0, "R1 irqOut");

    // R10 latching off while master bit 1 is clear
    drive(32'h0001_0008);
    drive(32'h0001_0008);
    drive(32'h0);
    rdChk(5'd0, 32'h0, "R10 no latch master off");
    wr(5'd28, 32'h3);
    rdChk(5'd28, 32'h3, "R10 master readback");

    // R7 direct enable, R5 / R6 aliases
    wr(5'd8, 32'h0000_00F0);
    rdChk(5'd8, 32'h0000_00F0, "R7 enable load");
    wr(5'd16, 32'h0001_0001);
    rdChk(5'd8, 32'h0001_00F1, "R5 set alias");
    wr(5'd20, 32'h0000_0030);
    rdChk(5'd8, 32'h0001_00C1, "R6 clear alias");

    // R2 edge source 5, masked
    drive(32'h0000_0020);
    rdChk(5'd0, 32'h0000_0020, "R2 edge latch");
    rdChk(5'd4, 32'h0, "R8 pending masked");
    irqChk(1'b0, "R10 irqOut masked");
    wr(5'd12, 32'h0000_0020);
    rdChk(5'd0, 32'h0, "R2 held edge no relatch");
    drive(32'h0);

    // R9 lowest index, R4 partial ack, R8 / R11 read-only
    drive(32'h0000_0041);
    rdChk(5'd0, 32'h0000_0041, "R2 two edges");
    rdChk(5'd4, 32'h0000_0041, "R8 pending");
    rdChk(5'd24, 32'h0, "R9 lowest vector");
    irqChk(1'b1, "R10 irqOut on");
    wr(5'd12, 32'h0000_0001);
    rdChk(5'd0, 32'h0000_0040, "R4 partial ack");
    rdChk(5'd24, 32'd6, "R9 next vector");
    wr(5'd4, 32'hFFFF_FFFF);
    rdChk(5'd4, 32'h0000_0040, "R8 pending write ignored");
    rdChk(5'd8, 32'h0001_00C1, "R8 enable untouched");
    wr(5'd0, 32'h0);
    rdChk(5'd0, 32'h0000_0040, "R11 status write ignored");
    drive(32'h0);

    // R3 level source 16
    drive(32'h0001_0000);
    rdChk(5'd0, 32'h0001_0040, "R3 level latch");
    wr(5'd12, 32'h0001_0000);
    rdChk(5'd0, 32'h0001_0040, "R3 level relatch");
    drive(32'h0);
    wr(5'd12, 32'hFFFF_FFFF);
    rdChk(5'd0, 32'h0, "R4 ack all");
    rdChk(5'd24, 32'hFFFF_FFFF, "R9 none pending");
    rdChk(5'd12, 32'h0, "R4 ack reads zero");
    irqChk(1'b0, "R10 irqOut idle");

    // R10 master bit 0 gates output
    drive(32'h0000_0001);
    drive(32'h0);
    irqChk(1'b1, "R10 irqOut pending");
    wr(5'd28, 32'h1);
    irqChk(1'b0, "R10 master bit1 off");
    wr(5'd28, 32'h2);
    irqChk(1'b0, "R10 master bit0 off");
    wr(5'd28, 32'h3);
    irqChk(1'b1, "R10 master back on");
    wr(5'd20, 32'h0000_0001);
    irqChk(1'b0, "R6 clear stops irq");
    rdChk(5'd0, 32'h0000_0001, "R6 status kept");

    // R10 level line held, latching off, then ack
    wr(5'd28, 32'h1);
    drive(32'h0002_0000);
    wr(5'd12, 32'hFFFF_FFFF);
    rdChk(5'd0, 32'h0, "R10 level ignored master off");
    drive(32'h0);

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

endmodule